// File: doc/BRIEF.md
# Bus Yield Controller

This block decides who drives a shared address, data and control bus: the local bus master or an external agent. The external agent raises a request line; the controller lets any transfer already underway run to its end and then grants the bus. Granting means raising a grant output and a single float output that turns off the local pad drivers. A lock input from the local side keeps the bus from being granted while an indivisible sequence is running.

A separate yield request forces the bus to be released at the next decision, even in the middle of a transfer. That transfer is abandoned. When the yield request goes away, the controller issues a one-cycle retry strobe so that the transfer engine starts the abandoned access again from its beginning. A yield request takes precedence over an external request. The controller also passes through, registered, whether the local bus controller has a request pending and whether the core is stalled on that request.

The external request, yield request and lock inputs pass through a synchronizer of `SYNC_STAGES` flops before any decision uses them. Reset is sampled on the clock, so that the controller can come out of reset already granting the bus.

Top module: `bus_yield_ctrl`

## Requirements
- R1: While rst_ni is low, each rising edge loads the granted state if the synchronized external request is high and the synchronized lock is low, and the owned state otherwise. retry_o, pend_o and stall_o are low. A grant loaded during reset is still held after rst_ni rises, as long as ext_req_i stays high.
- R2: ext_req_i, yield_req_i and lock_i are used only after SYNC_STAGES flops. A change on ext_req_i or yield_req_i sampled at rising edge k takes effect on the controller state at edge k+SYNC_STAGES. A change on lock_i sampled at edge k gates the grant from edge k+SYNC_STAGES-1.
- R3: If the external request is high while lock is low and no transfer is busy, ext_gnt_o and bus_float_o rise together and stay high while the request stays high.
- R4: If the external request arrives while xfer_busy_i is high, the grant is withheld until a cycle in which xfer_done_i is high or xfer_busy_i is low. The grant then follows at that edge.
- R5: When the synchronized external request goes low, ext_gnt_o and bus_float_o both fall at the next decision, and the local master drives the bus again.
- R6: ext_gnt_o is low whenever the synchronized lock is high. No grant is made while it stays high, and a grant already made is withdrawn.
- R7: A synchronized yield request seen in the owned or draining state raises bus_float_o at the next edge and keeps it high while the request lasts. ext_gnt_o stays low unless the bus was already granted.
- R8: When the yield request is released, bus_float_o falls. If a transfer was abandoned (busy without done at the edge it was abandoned), retry_o is high for exactly one cycle at that same edge. If no transfer was abandoned, retry_o stays low.
- R9: Yield takes priority over an external request. When both are active, the yield path is taken. No grant is made until the retried transfer signals xfer_done_i.
- R10: pend_o and stall_o are registered one cycle after the inputs. pend_o follows pend_i. stall_o is pend_i AND core_wait_i, so stall_o never rises without pend_o.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, sampled on the clock |
| ext_req_i | input | 1 | External agent requests the bus (asynchronous) |
| yield_req_i | input | 1 | Forced release with abort (asynchronous) |
| lock_i | input | 1 | Local indivisible sequence active (asynchronous) |
| xfer_busy_i | input | 1 | Local transfer in progress |
| xfer_done_i | input | 1 | Local transfer completes this cycle |
| pend_i | input | 1 | Request pending in the local bus controller |
| core_wait_i | input | 1 | Core is waiting on the pending request |
| ext_gnt_o | output | 1 | Bus granted to the external agent |
| bus_float_o | output | 1 | Turn off local bus drivers |
| retry_o | output | 1 | One-cycle strobe: reissue the abandoned transfer |
| pend_o | output | 1 | Registered pending-request status |
| stall_o | output | 1 | Registered core-stall status |

## Verification
The bench builds the controller with SYNC_STAGES set to 3 rather than the default 2. Every grant, release, lock and yield latency is therefore one cycle longer than at the default. The reference model keeps an input history indexed by that parameter, so an off-by-one in the stage chain or in the lock gating shows up as a mismatch. Fixed sequences cover these cases:
- reset with and without a request
- a request that drains behind a busy transfer
- grants blocked by lock and withdrawn by lock
- a yield that abandons a transfer and a yield with nothing to abandon
- a yield and a request raised together

A long pseudo-random stretch then mixes all the inputs.

// File: rtl/byc_pkg.sv
package byc_pkg;
  typedef enum logic [2:0] {
    ST_OWNED   = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_GRANTED = 3'd2,
    ST_YIELD   = 3'd3,
    ST_REISSUE = 3'd4
  } own_st_e;

  localparam int unsigned NUM_SYNC = 3;
  localparam int unsigned IDX_REQ  = 0;
  localparam int unsigned IDX_YLD  = 1;
  localparam int unsigned IDX_LOCK = 2;
endpackage

// File: rtl/byc_sync.sv
module byc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff_q [STAGES];

  // no reset: reset-time decisions must see the live request
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) ff_q[g] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i) ff_q[g] <= ff_q[g-1];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/byc_fsm.sv
module byc_fsm
  import byc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic yld_s_i,
  input  logic lock_s_i,
  input  logic busy_i,
  input  logic done_i,
  output logic gnt_o,
  output logic float_o,
  output logic retry_o
);
  own_st_e state_q, state_d;
  logic    abort_q, abort_d;
  logic    retry_q;
  logic    fin;

  assign fin = !busy_i || done_i;

  always_comb begin
    state_d = state_q;
    abort_d = abort_q;
    unique case (state_q)
      ST_OWNED: begin
        if (yld_s_i) begin
          state_d = ST_YIELD;
          abort_d = !fin;
        end else if (req_s_i && !fin) begin
          state_d = ST_DRAIN;
        end else if (req_s_i && !lock_s_i) begin
          state_d = ST_GRANTED;
        end
      end
      ST_DRAIN: begin
        if (yld_s_i) begin
          state_d = ST_YIELD;
          abort_d = !fin;
        end else if (!req_s_i) begin
          state_d = ST_OWNED;
        end else if (fin) begin
          state_d = lock_s_i ? ST_OWNED : ST_GRANTED;
        end
      end
      ST_GRANTED: begin
        if (!req_s_i || lock_s_i) state_d = ST_OWNED;
      end
      ST_YIELD: begin
        if (!yld_s_i) state_d = abort_q ? ST_REISSUE : ST_OWNED;
      end
      ST_REISSUE: begin
        if (yld_s_i) begin
          state_d = ST_YIELD;
          abort_d = !done_i;
        end else if (done_i) begin
          state_d = (req_s_i && !lock_s_i) ? ST_GRANTED : ST_OWNED;
        end
      end
      default: state_d = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= (req_s_i && !lock_s_i) ? ST_GRANTED : ST_OWNED;
      abort_q <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
      retry_q <= (state_q == ST_YIELD) && !yld_s_i && abort_q;
    end
  end

  assign gnt_o   = (state_q == ST_GRANTED) && !lock_s_i;
  assign float_o = (state_q == ST_GRANTED) || (state_q == ST_YIELD);
  assign retry_o = retry_q;

  AST_LOCK_BLOCKS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_s_i |=> (state_q != ST_GRANTED)); // R6
  AST_GRANT_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> float_o); // R3
  AST_YIELD_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (yld_s_i && (state_q == ST_OWNED || state_q == ST_DRAIN)) |=> float_o && !gnt_o); // R7
  AST_RETRY_AFTER_YIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> (state_q == ST_REISSUE) && !float_o); // R8
  AST_RETRY_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !retry_o); // R8
  AST_DRAIN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && busy_i && !done_i) |=> !gnt_o); // R4
  AST_REISSUE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REISSUE && !done_i) |=> !gnt_o); // R9
endmodule

// File: rtl/byc_status.sv
module byc_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic core_wait_i,
  output logic pend_o,
  output logic stall_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_o  <= 1'b0;
      stall_o <= 1'b0;
    end else begin
      pend_o  <= pend_i;
      stall_o <= pend_i && core_wait_i;
    end
  end

  AST_STALL_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> pend_o); // R10
endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
  import byc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_req_i,
  input  logic yield_req_i,
  input  logic lock_i,
  input  logic xfer_busy_i,
  input  logic xfer_done_i,
  input  logic pend_i,
  input  logic core_wait_i,
  output logic ext_gnt_o,
  output logic bus_float_o,
  output logic retry_o,
  output logic pend_o,
  output logic stall_o
);
  logic [NUM_SYNC-1:0] raw, synced;

  assign raw[IDX_REQ]  = ext_req_i;
  assign raw[IDX_YLD]  = yield_req_i;
  assign raw[IDX_LOCK] = lock_i;

  byc_sync #(.W(NUM_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (raw),
    .q_o   (synced)
  );

  byc_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_s_i  (synced[IDX_REQ]),
    .yld_s_i  (synced[IDX_YLD]),
    .lock_s_i (synced[IDX_LOCK]),
    .busy_i   (xfer_busy_i),
    .done_i   (xfer_done_i),
    .gnt_o    (ext_gnt_o),
    .float_o  (bus_float_o),
    .retry_o  (retry_o)
  );

  byc_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend_i),
    .core_wait_i (core_wait_i),
    .pend_o      (pend_o),
    .stall_o     (stall_o)
  );
endmodule

// File: tb/bus_yield_ctrl_tb.sv
`timescale 1ns/1ps
module bus_yield_ctrl_tb;
  localparam int STG = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_req = 0, yld = 0, lock = 0, busy = 0, done = 0, pend = 0, cwait = 0;
  logic gnt, flt, rty, pend_q, stall_q;

  int tests = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  bus_yield_ctrl #(.SYNC_STAGES(STG)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_req_i(ext_req), .yield_req_i(yld),
    .lock_i(lock), .xfer_busy_i(busy), .xfer_done_i(done), .pend_i(pend),
    .core_wait_i(cwait), .ext_gnt_o(gnt), .bus_float_o(flt), .retry_o(rty),
    .pend_o(pend_q), .stall_o(stall_q)
  );

  // reference model: 0 owned, 1 drain, 2 granted, 3 yield, 4 reissue
  logic hq [STG], yq [STG], lq [STG];
  int   ms = 0;
  logic mab = 0, mrt = 0, mpend = 0, mstall = 0;

  initial for (int i = 0; i < STG; i++) begin hq[i] = 0; yq[i] = 0; lq[i] = 0; end

  always @(posedge clk) begin
    logic h, y, l, fin;
    int   ns;
    logic nab, nrt;
    h = hq[STG-1]; y = yq[STG-1]; l = lq[STG-1];
    fin = !busy || done;
    ns = ms; nab = mab; nrt = 0;
    if (!rst_ni) begin
      ns = (h && !l) ? 2 : 0; nab = 0;
      mpend = 0; mstall = 0;
    end else begin
      if (ms == 0) begin
        if (y) begin ns = 3; nab = !fin; end
        else if (h && !fin) ns = 1;
        else if (h && !l) ns = 2;
      end else if (ms == 1) begin
        if (y) begin ns = 3; nab = !fin; end
        else if (!h) ns = 0;
        else if (fin) ns = l ? 0 : 2;
      end else if (ms == 2) begin
        if (!h || l) ns = 0;
      end else if (ms == 3) begin
        if (!y) begin ns = mab ? 4 : 0; nrt = mab; end
      end else begin
        if (y) begin ns = 3; nab = !done; end
        else if (done) ns = (h && !l) ? 2 : 0;
      end
      mpend = pend; mstall = pend && cwait;
    end
    ms = ns; mab = nab; mrt = nrt;
    for (int i = STG-1; i > 0; i--) begin hq[i] = hq[i-1]; yq[i] = yq[i-1]; lq[i] = lq[i-1]; end
    hq[0] = ext_req; yq[0] = yld; lq[0] = lock;
    cyc++;
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (cyc > STG + 2) begin
      chk("R3", "ext_gnt_o model", gnt, (ms == 2) && !lq[STG-1]);
      chk("R7", "bus_float_o model", flt, (ms == 2) || (ms == 3));
      chk("R8", "retry_o model", rty, mrt);
      chk("R10", "pend_o model", pend_q, mpend);
      chk("R10", "stall_o model", stall_q, mstall);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_xfer();
    done = 1; busy = 1; step(); done = 0; busy = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset with no request
    pend = 1; steps(8);
    chk("R1", "gnt in reset", gnt, 0);
    chk("R1", "float in reset", flt, 0);
    chk("R1", "retry in reset", rty, 0);
    chk("R1", "pend in reset", pend_q, 0);
    rst_ni = 1; pend = 0; steps(2);

    // R2 / R3: idle grant latency STG+1 steps
    ext_req = 1; steps(STG);
    chk("R2", "gnt before sync latency", gnt, 0);
    step();
    chk("R3", "gnt idle", gnt, 1);
    chk("R3", "float with grant", flt, 1);
    steps(5);
    chk("R3", "gnt held", gnt, 1);
    // R5
    ext_req = 0; steps(STG + 1);
    chk("R5", "gnt released", gnt, 0);
    chk("R5", "float released", flt, 0);

    // R4: drain behind busy transfer
    busy = 1; steps(2); ext_req = 1; steps(8);
    chk("R4", "gnt withheld while busy", gnt, 0);
    finish_xfer();
    chk("R4", "gnt at done", gnt, 1);
    ext_req = 0; steps(STG + 2);

    // R6: lock blocks and withdraws
    lock = 1; steps(STG + 1); ext_req = 1; steps(8);
    chk("R6", "no grant under lock", gnt, 0);
    lock = 0; steps(STG + 1);
    chk("R6", "grant after unlock", gnt, 1);
    lock = 1; steps(STG);
    chk("R6", "grant withdrawn by lock", gnt, 0);
    lock = 0; ext_req = 0; steps(6);

    // R7 / R8: yield aborting a busy transfer
    busy = 1; steps(2); yld = 1; steps(STG);
    chk("R7", "float before sync latency", flt, 0);
    step();
    chk("R7", "float on yield", flt, 1);
    chk("R7", "no grant on yield", gnt, 0);
    steps(5);
    chk("R7", "float held", flt, 1);
    yld = 0; steps(STG);
    chk("R8", "no retry yet", rty, 0);
    step();
    chk("R8", "retry strobe", rty, 1);
    chk("R8", "float off at retry", flt, 0);
    step();
    chk("R8", "retry one shot", rty, 0);
    finish_xfer(); steps(3);

    // R8: nothing abandoned -> no retry
    yld = 1; steps(6); yld = 0; steps(STG + 1);
    chk("R8", "no retry without abort", rty, 0);
    chk("R8", "float off", flt, 0);
    steps(2);

    // R9: yield and request together
    busy = 1; step(); ext_req = 1; yld = 1; steps(STG + 1);
    chk("R9", "yield wins float", flt, 1);
    chk("R9", "yield wins no grant", gnt, 0);
    yld = 0; steps(STG + 1);
    chk("R9", "retry issued", rty, 1);
    chk("R9", "no grant at retry", gnt, 0);
    steps(4);
    chk("R9", "no grant before retried done", gnt, 0);
    finish_xfer();
    chk("R9", "grant after retried done", gnt, 1);
    ext_req = 0; steps(STG + 2);

    // R10
    pend = 1; cwait = 0; step();
    chk("R10", "pend passes", pend_q, 1);
    chk("R10", "no stall", stall_q, 0);
    cwait = 1; step();
    chk("R10", "stall", stall_q, 1);
    pend = 0; step();
    chk("R10", "stall drops with pend", stall_q, 0);
    chk("R10", "pend drops", pend_q, 0);
    cwait = 0;

    // R1: request during reset is granted and kept
    ext_req = 1; rst_ni = 0; steps(STG + 3);
    chk("R1", "grant in reset", gnt, 1);
    chk("R1", "float in reset", flt, 1);
    rst_ni = 1; steps(2);
    chk("R1", "grant kept after reset", gnt, 1);
    ext_req = 0; steps(STG + 2);

    // random mix, model compared every cycle
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd0) ext_req = ~ext_req;
      if (lfsr[8:4] == 5'd0) yld = ~yld;
      if (lfsr[11:9] == 3'd0 && lfsr[1]) lock = ~lock;
      if (busy) begin done = lfsr[12] & lfsr[5]; busy = ~done | lfsr[14]; end
      else begin done = 0; busy = lfsr[13] & lfsr[2]; end
      pend = lfsr[6]; cwait = lfsr[7];
      step();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule